// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command interpreter of a small serial flash model. A host drives chip-select (active low), a serial clock and a serial data input. The block returns bytes on a serial data output with a separate output-enable, which the pad driver uses to put the line in high impedance. Every byte on the wire is one bus cycle of eight serial clocks, sent most significant bit first. Input bits are taken on rising serial-clock edges and output bits change on falling edges, so hosts that idle the clock low and hosts that idle it high are both served.

The block handles five commands. An array read starts at a 24-bit address and streams sequential bytes, wrapping at the top of the configured density. A status read streams the status byte again and again. An identification read alternates a manufacturer code and a device code. Two different opcodes arm a status write, and a status-write opcode with one data byte then updates the status register. The storage is a small register array whose size is a power of two. The testbench fills it through a preload port. Internally the serial pins are oversampled on a fast system clock.

Top module: `spif_front`

## Requirements
- R1: Opcode, address and data bytes are sampled most significant bit first on rising serial-clock edges while chip-select is low; the output bit changes only after a falling serial-clock edge.
- R2: Opcode 8'h03 followed by three address bytes (bits 23..0) starts an array read; the first data bit appears on the falling edge after the last address bit and bytes follow from consecutive addresses while chip-select stays low.
- R3: After the highest address of the configured density the read pointer continues at address 0.
- R4: Address bits at and above log2(MEM_BYTES) are ignored.
- R5: Opcode 8'h05 streams the status byte repeatedly until chip-select rises; status bit 0 (busy) reads 0, bit 1 is the write-enable latch, bits 7..2 are the writable field.
- R6: Opcode 8'h90 followed by three address bytes streams the manufacturer code first when address bit 0 is 0 and the device code first when it is 1, alternating afterwards.
- R7: Opcode 8'h01 followed by one data byte loads bits 7..2 of that byte into the status register only when the previous completed command was 8'h06 or 8'h50; otherwise the status is unchanged.
- R8: Opcode 8'h06 sets the write-enable latch; 8'h50 arms a status write without setting it; a completed status write clears it.
- R9: Chip-select rising in the middle of an opcode, address or status-write data byte aborts the command and clears both the write-enable latch and the armed state.
- R10: The output enable is low whenever chip-select is high, during opcode and address bytes, and after reset.
- R11: Hosts that idle the serial clock low and hosts that idle it high get identical results.
- R12: An unknown opcode leaves the output disabled and the status unchanged until chip-select rises.
- R13: A write on the preload port stores a byte that a later array read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the serial data pad |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | AW | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
On every cycle, assertions check four things: the output enable appears only in a data phase, the output bit moves only on a falling serial-clock edge, an aborted command leaves no latch or armed state, and the status field changes only through an armed write. They also check that the read pointer steps from the top address to zero and that the identification selector flips at each byte boundary. Only the bench scenarios can show the actual byte values: the wrap in context, the ignored upper address bits, the behaviour under both clock polarities, and whether a given command sequence arms a status write.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_EWSR = 8'h50;
    localparam logic [7:0] OP_RDID = 8'h90;

    localparam int OPC_LAST  = 7;   // bit index of last opcode bit in a frame
    localparam int ADDR_LAST = 31;  // bit index of last address bit
    localparam int WDAT_LAST = 15;  // bit index of last status-write data bit

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_DATA,
        PH_DONE
    } spif_phase_e;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_STAT,
        SRC_ID
    } spif_src_e;

    function automatic logic [7:0] stat_pack(input logic [5:0] hi, input logic wel);
        return {hi, wel, 1'b0};
    endfunction

endpackage

// File: rtl/spif_edge.sv
module spif_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;

endmodule

// File: rtl/spif_cmd.sv
module spif_cmd
    import spif_pkg::*;
#(
    parameter int AW = 8,
    localparam int SW = (AW > 8) ? AW : 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          si,
    input  logic          sck_rise,
    input  logic          cs_rise,
    output spif_phase_e   phase,
    output logic          start_pulse,
    output spif_src_e     start_src,
    output logic [AW-1:0] start_addr,
    output logic [7:0]    stat
);
    spif_phase_e   phase_q;
    logic [5:0]    bit_cnt;
    logic [SW-2:0] sh;
    logic [SW-1:0] nxt;
    logic [7:0]    op_q;
    logic          arm_q;
    logic          wel_q;
    logic [5:0]    stat_hi;
    logic          abort;

    assign nxt   = {sh, si};
    assign abort = (phase_q == PH_OPC && bit_cnt != 6'd0) ||
                   (phase_q == PH_ADDR) || (phase_q == PH_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_OPC;
            bit_cnt     <= '0;
            sh          <= '0;
            op_q        <= '0;
            arm_q       <= 1'b0;
            wel_q       <= 1'b0;
            stat_hi     <= '0;
            start_pulse <= 1'b0;
            start_src   <= SRC_MEM;
            start_addr  <= '0;
        end else begin
            start_pulse <= 1'b0;
            if (cs_rise) begin
                phase_q <= PH_OPC;
                bit_cnt <= '0;
                if (abort) begin
                    arm_q <= 1'b0;
                    wel_q <= 1'b0;
                end
            end else if (sck_rise) begin
                sh <= nxt[SW-2:0];
                if (bit_cnt != 6'h3f) bit_cnt <= bit_cnt + 6'd1;
                case (phase_q)
                    PH_OPC: begin
                        if (bit_cnt == 6'(OPC_LAST)) begin
                            op_q <= nxt[7:0];
                            case (nxt[7:0])
                                OP_READ: begin
                                    phase_q   <= PH_ADDR;
                                    start_src <= SRC_MEM;
                                    arm_q     <= 1'b0;
                                end
                                OP_RDID: begin
                                    phase_q   <= PH_ADDR;
                                    start_src <= SRC_ID;
                                    arm_q     <= 1'b0;
                                end
                                OP_RDSR: begin
                                    phase_q     <= PH_DATA;
                                    start_src   <= SRC_STAT;
                                    start_pulse <= 1'b1;
                                    arm_q       <= 1'b0;
                                end
                                OP_WRSR: phase_q <= PH_WDATA;
                                OP_WREN: begin
                                    phase_q <= PH_DONE;
                                    wel_q   <= 1'b1;
                                    arm_q   <= 1'b1;
                                end
                                OP_EWSR: begin
                                    phase_q <= PH_DONE;
                                    arm_q   <= 1'b1;
                                end
                                default: begin
                                    phase_q <= PH_DONE;
                                    arm_q   <= 1'b0;
                                end
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        if (bit_cnt == 6'(ADDR_LAST)) begin
                            start_addr  <= nxt[AW-1:0];
                            start_pulse <= 1'b1;
                            phase_q     <= PH_DATA;
                        end
                    end
                    PH_WDATA: begin
                        if (bit_cnt == 6'(WDAT_LAST)) begin
                            if (arm_q) begin
                                stat_hi <= nxt[7:2];
                                wel_q   <= 1'b0;
                            end
                            arm_q   <= 1'b0;
                            phase_q <= PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign phase = phase_q;
    assign stat  = stat_pack(stat_hi, wel_q);

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && abort) |=> (!wel_q && !arm_q)); // R9
    AST_STAT_GATED: assert property (@(posedge clk) disable iff (rst)
        !(sck_rise && phase_q == PH_WDATA && arm_q) |=> $stable(stat_hi)); // R7
    AST_WEL_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(wel_q) |-> (op_q == OP_WREN)); // R8

endmodule

// File: rtl/spif_out.sv
module spif_out
    import spif_pkg::*;
#(
    parameter int          AW     = 8,
    parameter logic [7:0]  MFR_ID = 8'hC3,
    parameter logic [7:0]  DEV_ID = 8'h4E
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck_fall,
    input  logic          cs_rise,
    input  spif_phase_e   phase,
    input  logic          start_pulse,
    input  spif_src_e     start_src,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    stat,
    input  logic [7:0]    mem_data,
    output logic [AW-1:0] mem_addr,
    output logic          so,
    output logic          so_oe
);
    spif_src_e     src_q;
    logic [AW-1:0] ptr;
    logic          id_sel;
    logic [2:0]    obit;
    logic          so_q;
    logic          oe_q;
    logic [7:0]    cur_byte;
    logic          data_active;

    assign data_active = (phase == PH_DATA);

    always_comb begin
        case (src_q)
            SRC_STAT: cur_byte = stat;
            SRC_ID:   cur_byte = id_sel ? DEV_ID : MFR_ID;
            default:  cur_byte = mem_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_MEM;
            ptr    <= '0;
            id_sel <= 1'b0;
            obit   <= 3'd7;
            so_q   <= 1'b0;
            oe_q   <= 1'b0;
        end else if (cs_rise) begin
            oe_q <= 1'b0;
        end else if (start_pulse) begin
            src_q  <= start_src;
            ptr    <= start_addr;
            id_sel <= start_addr[0];
            obit   <= 3'd7;
        end else if (sck_fall && data_active) begin
            so_q <= cur_byte[obit];
            oe_q <= 1'b1;
            obit <= obit - 3'd1;
            if (obit == 3'd0) begin
                ptr    <= ptr + 1'b1;
                id_sel <= ~id_sel;
            end
        end
    end

    assign mem_addr = ptr;
    assign so       = so_q;
    assign so_oe    = oe_q & ~cs_n;

    AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> data_active); // R10
    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !sck_fall |=> $stable(so_q)); // R1
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sck_fall && data_active && !start_pulse && obit == 3'd0 &&
         src_q == SRC_MEM && ptr == {AW{1'b1}}) |=> (ptr == '0)); // R3
    AST_ID_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (sck_fall && data_active && !start_pulse && obit == 3'd0 &&
         src_q == SRC_ID) |=> (id_sel != $past(id_sel))); // R6

endmodule

// File: rtl/spif_mem.sv
module spif_mem #(
    parameter int BYTES = 256,
    localparam int AW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] arr [BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) arr[wr_addr] <= wr_data;
    end

    assign rd_data = arr[rd_addr];

endmodule

// File: rtl/spif_front.sv
module spif_front
    import spif_pkg::*;
#(
    parameter int         MEM_BYTES = 256,
    parameter logic [7:0] MFR_ID    = 8'hC3,
    parameter logic [7:0] DEV_ID    = 8'h4E,
    localparam int        AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    output logic          so,
    output logic          so_oe,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [7:0]    pl_data
);
    logic          sck_rise, sck_fall, cs_rise;
    spif_phase_e   phase;
    logic          start_pulse;
    spif_src_e     start_src;
    logic [AW-1:0] start_addr;
    logic [7:0]    stat;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;

    spif_edge edge_i (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spif_cmd #(.AW(AW)) cmd_i (
        .clk(clk), .rst(rst), .si(si), .sck_rise(sck_rise), .cs_rise(cs_rise),
        .phase(phase), .start_pulse(start_pulse), .start_src(start_src),
        .start_addr(start_addr), .stat(stat)
    );

    spif_out #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) out_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .phase(phase), .start_pulse(start_pulse), .start_src(start_src),
        .start_addr(start_addr), .stat(stat), .mem_data(mem_data),
        .mem_addr(mem_addr), .so(so), .so_oe(so_oe)
    );

    spif_mem #(.BYTES(MEM_BYTES)) mem_i (
        .clk(clk), .wr_en(pl_we), .wr_addr(pl_addr), .wr_data(pl_data),
        .rd_addr(mem_addr), .rd_data(mem_data)
    );

endmodule

// File: tb/spif_front_tb_top.sv
module spif_front_tb_top;

    localparam int         MEM_BYTES = 256;
    localparam int         AW        = 8;
    localparam logic [7:0] MFR       = 8'hC3;
    localparam logic [7:0] DEV       = 8'h4E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;
    logic pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [7:0] pl_data = '0;

    always #2 clk = ~clk;

    spif_front #(.MEM_BYTES(MEM_BYTES), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit mode3 = 0;
    logic [7:0] model [MEM_BYTES];
    logic [7:0] stat_m = 8'h00;
    logic [7:0] exp_q [$];
    string req_q [$];
    logic mon_en = 1'b0;
    int mon_bits = 0;
    logic [7:0] mon_sh = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: samples the host side on rising serial clock, compares per byte
    always @(posedge sck) begin
        if (mon_en) begin
            mon_sh = {mon_sh[6:0], so};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: actual %0h expected none", mon_sh);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string r = req_q.pop_front();
                    if (mon_sh !== e || so_oe !== 1'b1) begin
                        n_fail++;
                        $display("FAIL %s: actual %0h expected %0h", r, mon_sh, e);
                    end
                end
            end
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        if (mode3) begin
            sck = 1'b0; si = b; half(); sck = 1'b1; half();
        end else begin
            si = b; half(); sck = 1'b1; half(); sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic begin_frame();
        sck = mode3; half(); cs_n = 1'b0; half();
    endtask

    task automatic end_frame();
        half(); mon_en = 1'b0; mon_bits = 0; cs_n = 1'b1; half(); half();
    endtask

    task automatic expect_byte(input logic [7:0] e, input string req);
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic drain(input int n, input string req);
        mon_bits = 0;
        mon_en = 1'b1;
        for (int i = 0; i < n; i++) send_byte(8'h00);
        end_frame();
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        req_q.delete();
    endtask

    task automatic read_mem(input logic [23:0] a, input int n, input string req);
        begin_frame();
        send_byte(8'h03);
        chk(so_oe == 1'b0, "R10 opcode phase", so_oe, 0);
        send_byte(a[23:16]); send_byte(a[15:8]);
        chk(so_oe == 1'b0, "R10 address phase", so_oe, 0);
        send_byte(a[7:0]);
        for (int i = 0; i < n; i++) expect_byte(model[(int'(a) + i) % MEM_BYTES], req);
        drain(n, req);
    endtask

    task automatic read_stat(input int n, input string req);
        begin_frame();
        send_byte(8'h05);
        for (int i = 0; i < n; i++) expect_byte(stat_m, req);
        drain(n, req);
    endtask

    task automatic read_id(input logic a0, input int n, input string req);
        begin_frame();
        send_byte(8'h90); send_byte(8'h00); send_byte(8'h00); send_byte({7'd0, a0});
        for (int i = 0; i < n; i++) expect_byte(((i % 2) == int'(a0)) ? MFR : DEV, req);
        drain(n, req);
    endtask

    task automatic cmd1(input logic [7:0] op);
        begin_frame(); send_byte(op); end_frame();
    endtask

    task automatic wrsr(input logic [7:0] d);
        begin_frame(); send_byte(8'h01); send_byte(d); end_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R13: preload the array through the side port
        for (int i = 0; i < MEM_BYTES; i++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = AW'(i); pl_data = 8'(i * 37 + 11);
            model[i] = 8'(i * 37 + 11);
        end
        @(negedge clk); pl_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0, "R10 after reset", so_oe, 0);

        read_stat(3, "R5 R1 reset status");
        read_mem(24'h000010, 5, "R2 R13 sequential read");
        chk(so_oe == 1'b0, "R10 chip-select high", so_oe, 0);
        read_mem(24'h0000FD, 6, "R3 wrap to zero");
        mode3 = 1;
        read_mem(24'hAB0020, 4, "R4 R11 upper bits ignored idle-high clock");
        read_id(1'b1, 3, "R6 R11 device code first");
        mode3 = 0;
        read_id(1'b0, 4, "R6 manufacturer code first");

        // R7: status write with no enable has no effect
        wrsr(8'hFC);
        read_stat(1, "R7 unarmed write ignored");
        cmd1(8'h06); stat_m = 8'h02;
        read_stat(2, "R8 write-enable sets latch");
        wrsr(8'hFC);
        read_stat(1, "R7 status read breaks arming");
        cmd1(8'h06);
        wrsr(8'hFC); stat_m = 8'hFC;
        read_stat(2, "R7 R8 armed write then latch clear");
        cmd1(8'h50);
        wrsr(8'h57); stat_m = 8'h54;
        read_stat(1, "R7 second enabling opcode");
        cmd1(8'h50);
        read_stat(1, "R8 second enabling opcode leaves latch");

        // R9: aborted commands
        cmd1(8'h06); stat_m = 8'h56;
        read_stat(1, "R8 latch before abort");
        begin_frame(); send_byte(8'h01);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        end_frame(); stat_m = 8'h54;
        read_stat(1, "R9 abort in data byte");
        cmd1(8'h06);
        begin_frame(); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); end_frame();
        wrsr(8'h00);
        read_stat(1, "R9 abort in opcode clears arming");

        // R12: unknown opcode
        begin_frame(); send_byte(8'hA7); send_byte(8'hFF);
        chk(so_oe == 1'b0, "R12 unknown opcode output", so_oe, 0);
        send_byte(8'h01);
        chk(so_oe == 1'b0, "R12 unknown opcode trailing bits", so_oe, 0);
        end_frame();
        read_stat(1, "R12 status unchanged");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule